// File: doc/BRIEF.md
# Page-Mode DRAM Access Sequencer

This block sits between a processor bus and a DRAM array split into banks. When it sees the address strobe, it breaks the processor address into a bank, a row and a column. It then drives one RAS line per bank, a multiplexed address bus, a shared CAS line and an active-low transfer acknowledge back to the processor. After each access the row is left open. The next strobe is compared against that open row: a match takes the short page-hit path, and a mismatch precharges and reopens. While the processor holds its burst request, the block steps the column inside an aligned wrap block and starts a new beat by itself.

The number of wait states for each access kind, the precharge length and the burst wrap size are static configuration inputs. Refresh is done by a separate block through a request/grant pair. The sequencer closes any open row and precharges it, then grants the refresh. Any strobe that arrives while the refresh is pending is held and served afterwards as an opening access.

Top module: `dram_page_seq`

## Requirements
- R1: While `rst` is high at a clock edge, all `ras_n` bits, `cas_n` and `dtack_n` are driven high and `ref_gnt` is driven low.
- R2: When `ads_n` is sampled low at edge E with the sequencer idle, the RAS of the bank in the address top bit(s) goes low from edge E and `ma` carries the row (`addr[COL_W+:ROW_W]`). From edge E+1, `ma` carries the column (`addr[COL_W-1:0]`) and `cas_n` is low. At most one RAS is low at any time.
- R3: In an opening access, `dtack_n` goes low from edge E+1+`cfg_open_wait`.
- R4: `dtack_n` is low for exactly one clock. `cas_n` rises on the same edge where `dtack_n` rises.
- R5: When an access ends with `burst_req` low, only `cas_n` rises. The RAS of the accessed bank stays low and the row stays open.
- R6: A strobe at edge E to the open bank and row (page hit) keeps RAS low, drives the new column on `ma` with `cas_n` low from edge E, and gives `dtack_n` low from edge E+`cfg_page_wait`.
- R7: A strobe at edge E to any other row or bank (page miss) drives all RAS high from edge E for max(1,`cfg_precharge`) clocks. The new bank's RAS then goes low with the new row on `ma`, and the access continues with opening timing.
- R8: If `burst_req` is high at edge D, where `dtack_n` rises, then `ma` shows the next column from D. `cas_n` goes low from D+1, and `dtack_n` goes low from D+1+`cfg_burst_wait`.
- R9: A burst increment changes only the low bits inside an aligned block of 2<<`cfg_wrap_sel` columns (0:2, 1:4, 2:8, 3:16). Stepping from the top of that block wraps to its base.
- R10: A `ref_req` seen while idle or with a row open gives `ref_gnt` high, after the precharge when a row was open, for as long as `ref_req` stays high, with all RAS high. The row is then closed, so the next access uses opening timing even if it targets the same row.
- R11: A strobe seen during refresh precharge or grant is held. `dtack_n` stays high until `ref_req` falls at edge R. The held access then opens at R with opening timing.
- R12: A strobe during an access that is in progress (row open, column, acknowledge or burst gap) is ignored. It changes neither `ma`, the acknowledge timing nor the open row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all activity on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ads_n | input | 1 | Address strobe from the processor, active low |
| addr | input | 20 | Processor address {bank, row, column} |
| burst_req | input | 1 | Processor burst request, active high |
| ref_req | input | 1 | Refresh request from the refresh block |
| cfg_open_wait | input | 3 | Wait states after CAS in an opening access |
| cfg_page_wait | input | 3 | Wait states after CAS in a page-hit access |
| cfg_burst_wait | input | 3 | Wait states after CAS in a burst beat |
| cfg_precharge | input | 3 | RAS precharge length in clocks (0 acts as 1) |
| cfg_wrap_sel | input | 2 | Burst wrap block size select |
| ras_n | output | 2 | Row strobe per bank, active low |
| cas_n | output | 1 | Column strobe, active low |
| ma | output | 10 | Multiplexed row/column address |
| dtack_n | output | 1 | Transfer acknowledge, active low |
| ref_gnt | output | 1 | Refresh grant, all rows closed |

## Verification
The bench is aimed at the points where off-by-one timing errors hide. These are the acknowledge edge for each of the three access kinds, the length of the precharge gap on a page miss, and the burst step that crosses the wrap boundary, where a design that ignores the mask would run into the next block (column 16 instead of 12). It also checks that a refresh really forgets the open row: a design that keeps the row valid would acknowledge a same-row request after one wait state instead of the opening count. A strobe issued in the middle of an access must not move `ma` or the open row, and a strobe issued during refresh must be neither lost nor acknowledged early.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ROW,
    ST_CAS,
    ST_ACK,
    ST_BGAP,
    ST_OPEN,
    ST_PMISS,
    ST_PREF,
    ST_REF
  } seq_state_t;

  typedef enum logic [1:0] {
    MA_HOLD,
    MA_ROW,
    MA_COL,
    MA_INC
  } ma_op_t;

endpackage

// File: rtl/dram_addr_path.sv
module dram_addr_path
  import dram_seq_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int ROW_W  = 10,
  parameter int BANK_W = 1,
  parameter int MA_W   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  ma_op_t            ma_op,
  input  logic [1:0]        wrap_sel,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [ROW_W-1:0]  in_row,
  input  logic [COL_W-1:0]  in_col,
  output logic [BANK_W-1:0] req_bank,
  output logic [ROW_W-1:0]  req_row,
  output logic [MA_W-1:0]   ma
);

  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [MA_W-1:0]   ma_q;
  logic [COL_W-1:0]  col_mask;
  logic [COL_W-1:0]  col_next;
  logic [ROW_W-1:0]  cur_row;
  logic [COL_W-1:0]  cur_col;

  always_comb begin
    col_mask = COL_W'((32'd2 << wrap_sel) - 32'd1);
    col_next = (col_q & ~col_mask) | ((col_q + COL_W'(1)) & col_mask);
    cur_row  = cap ? in_row : row_q;
    cur_col  = cap ? in_col : col_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      ma_q   <= '0;
    end else begin
      if (cap) begin
        bank_q <= in_bank;
        row_q  <= in_row;
        col_q  <= in_col;
      end else if (ma_op == MA_INC) begin
        col_q <= col_next;
      end
      case (ma_op)
        MA_ROW:  ma_q <= MA_W'(cur_row);
        MA_COL:  ma_q <= MA_W'(cur_col);
        MA_INC:  ma_q <= MA_W'(col_next);
        default: ma_q <= ma_q;
      endcase
    end
  end

  assign req_bank = bank_q;
  assign req_row  = row_q;
  assign ma       = ma_q;

  AST_WRAP_IN_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (ma_op == MA_INC && !cap) |=> ((col_q & ~$past(col_mask)) == ($past(col_q) & ~$past(col_mask)))); // R9

endmodule

// File: rtl/dram_page_track.sv
module dram_page_track #(
  parameter int ROW_W  = 10,
  parameter int BANK_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              open_set,
  input  logic              open_clr,
  input  logic [BANK_W-1:0] set_bank,
  input  logic [ROW_W-1:0]  set_row,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [ROW_W-1:0]  in_row,
  output logic              hit
);

  logic              valid_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      bank_q  <= '0;
      row_q   <= '0;
    end else if (open_clr) begin
      valid_q <= 1'b0;
    end else if (open_set) begin
      valid_q <= 1'b1;
      bank_q  <= set_bank;
      row_q   <= set_row;
    end
  end

  assign hit = valid_q && (in_bank == bank_q) && (in_row == row_q);

  AST_CLOSED_ROW_MISSES: assert property (@(posedge clk) disable iff (rst)
    open_clr |=> !hit); // R10

endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_seq_pkg::*;
#(
  parameter int BANK_W = 1,
  parameter int CW     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ads_n,
  input  logic              ref_req,
  input  logic              burst_req,
  input  logic              hit,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [CW-1:0]     cfg_open_wait,
  input  logic [CW-1:0]     cfg_page_wait,
  input  logic [CW-1:0]     cfg_burst_wait,
  input  logic [CW-1:0]     cfg_precharge,
  output logic              cap,
  output ma_op_t            ma_op,
  output logic              open_set,
  output logic              open_clr,
  output logic              ras_on_d,
  output logic [BANK_W-1:0] ras_bank_d,
  output logic              cas_n,
  output logic              dtack_n,
  output logic              ref_gnt
);

  seq_state_t        state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              pend_q, pend_d;
  logic              ras_on_q;
  logic [BANK_W-1:0] bank_q;
  logic              cas_q, cas_d;
  logic              dtack_q, dtack_d;
  logic              gnt_q, gnt_d;
  logic              do_col, do_open;
  logic [CW-1:0]     col_wait;
  logic [CW-1:0]     pre_load;

  assign pre_load = (cfg_precharge == '0) ? '0 : cfg_precharge - CW'(1);

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    pend_d     = pend_q;
    cap        = 1'b0;
    ma_op      = MA_HOLD;
    open_set   = 1'b0;
    open_clr   = 1'b0;
    ras_on_d   = ras_on_q;
    ras_bank_d = bank_q;
    cas_d      = 1'b1;
    dtack_d    = 1'b1;
    gnt_d      = 1'b0;
    do_col     = 1'b0;
    do_open    = 1'b0;
    col_wait   = '0;
    case (state_q)
      ST_IDLE: begin
        if (ref_req) begin
          state_d = ST_REF;
          gnt_d   = 1'b1;
          if (!ads_n) begin
            pend_d = 1'b1;
            cap    = 1'b1;
          end
        end else if (!ads_n) begin
          cap     = 1'b1;
          do_open = 1'b1;
        end
      end
      ST_ROW: begin
        ma_op    = MA_COL;
        do_col   = 1'b1;
        col_wait = cfg_open_wait;
      end
      ST_CAS: begin
        cas_d = 1'b0;
        if (cnt_q == '0) begin
          state_d = ST_ACK;
          dtack_d = 1'b0;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      ST_ACK: begin
        if (burst_req) begin
          state_d = ST_BGAP;
          ma_op   = MA_INC;
        end else begin
          state_d = ST_OPEN;
        end
      end
      ST_BGAP: begin
        do_col   = 1'b1;
        col_wait = cfg_burst_wait;
      end
      ST_OPEN: begin
        if (ref_req) begin
          state_d  = ST_PREF;
          ras_on_d = 1'b0;
          open_clr = 1'b1;
          cnt_d    = pre_load;
          if (!ads_n) begin
            pend_d = 1'b1;
            cap    = 1'b1;
          end
        end else if (!ads_n) begin
          cap = 1'b1;
          if (hit) begin
            ma_op    = MA_COL;
            do_col   = 1'b1;
            col_wait = cfg_page_wait;
          end else begin
            state_d  = ST_PMISS;
            ras_on_d = 1'b0;
            open_clr = 1'b1;
            cnt_d    = pre_load;
          end
        end
      end
      ST_PMISS: begin
        if (cnt_q == '0) do_open = 1'b1;
        else cnt_d = cnt_q - CW'(1);
      end
      ST_PREF: begin
        if (!ads_n && !pend_q) begin
          pend_d = 1'b1;
          cap    = 1'b1;
        end
        if (cnt_q == '0) begin
          state_d = ST_REF;
          gnt_d   = 1'b1;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      ST_REF: begin
        if (ref_req) begin
          gnt_d = 1'b1;
          if (!ads_n && !pend_q) begin
            pend_d = 1'b1;
            cap    = 1'b1;
          end
        end else if (pend_q || !ads_n) begin
          cap     = !pend_q;
          pend_d  = 1'b0;
          do_open = 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (do_open) begin
      state_d    = ST_ROW;
      ma_op      = MA_ROW;
      open_set   = 1'b1;
      ras_on_d   = 1'b1;
      ras_bank_d = cap ? in_bank : req_bank;
    end
    if (do_col) begin
      cas_d = 1'b0;
      if (col_wait == '0) begin
        state_d = ST_ACK;
        dtack_d = 1'b0;
      end else begin
        state_d = ST_CAS;
        cnt_d   = col_wait - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      pend_q   <= 1'b0;
      ras_on_q <= 1'b0;
      bank_q   <= '0;
      cas_q    <= 1'b1;
      dtack_q  <= 1'b1;
      gnt_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      pend_q   <= pend_d;
      ras_on_q <= ras_on_d;
      bank_q   <= ras_bank_d;
      cas_q    <= cas_d;
      dtack_q  <= dtack_d;
      gnt_q    <= gnt_d;
    end
  end

  assign cas_n   = cas_q;
  assign dtack_n = dtack_q;
  assign ref_gnt = gnt_q;

  AST_DTACK_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    !dtack_n |=> dtack_n); // R4
  AST_CAS_RISES_WITH_DTACK: assert property (@(posedge clk) disable iff (rst)
    $rose(dtack_n) |-> $rose(cas_n)); // R4
  AST_GNT_ROWS_CLOSED: assert property (@(posedge clk) disable iff (rst)
    ref_gnt |-> !ras_on_q); // R10
  AST_HIT_CAS_AT_ONCE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OPEN && !ads_n && !ref_req && hit) |=> !cas_n); // R6
  AST_MISS_CLOSES_ROW: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OPEN && !ads_n && !ref_req && !hit) |=> (!ras_on_q && cas_n)); // R7
  AST_NO_ACK_IN_REFRESH: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_REF) |-> dtack_n); // R11

endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq
  import dram_seq_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int ROW_W  = 10,
  parameter int BANK_W = 1,
  parameter int CW     = 3,
  localparam int ADDR_W = BANK_W + ROW_W + COL_W,
  localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int BANKS  = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ads_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              burst_req,
  input  logic              ref_req,
  input  logic [CW-1:0]     cfg_open_wait,
  input  logic [CW-1:0]     cfg_page_wait,
  input  logic [CW-1:0]     cfg_burst_wait,
  input  logic [CW-1:0]     cfg_precharge,
  input  logic [1:0]        cfg_wrap_sel,
  output logic [BANKS-1:0]  ras_n,
  output logic              cas_n,
  output logic [MA_W-1:0]   ma,
  output logic              dtack_n,
  output logic              ref_gnt
);

  logic [BANK_W-1:0] in_bank, req_bank, ras_bank_d, set_bank;
  logic [ROW_W-1:0]  in_row, req_row, set_row;
  logic [COL_W-1:0]  in_col;
  logic              cap, open_set, open_clr, ras_on_d, hit;
  ma_op_t            ma_op;

  assign in_col  = addr[COL_W-1:0];
  assign in_row  = addr[COL_W +: ROW_W];
  assign in_bank = addr[ADDR_W-1 -: BANK_W];

  assign set_bank = cap ? in_bank : req_bank;
  assign set_row  = cap ? in_row  : req_row;

  dram_addr_path #(
    .COL_W(COL_W), .ROW_W(ROW_W), .BANK_W(BANK_W), .MA_W(MA_W)
  ) u_addr (
    .clk(clk), .rst(rst), .cap(cap), .ma_op(ma_op), .wrap_sel(cfg_wrap_sel),
    .in_bank(in_bank), .in_row(in_row), .in_col(in_col),
    .req_bank(req_bank), .req_row(req_row), .ma(ma)
  );

  dram_page_track #(
    .ROW_W(ROW_W), .BANK_W(BANK_W)
  ) u_page (
    .clk(clk), .rst(rst), .open_set(open_set), .open_clr(open_clr),
    .set_bank(set_bank), .set_row(set_row),
    .in_bank(in_bank), .in_row(in_row), .hit(hit)
  );

  dram_seq_fsm #(
    .BANK_W(BANK_W), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst(rst), .ads_n(ads_n), .ref_req(ref_req), .burst_req(burst_req),
    .hit(hit), .in_bank(in_bank), .req_bank(req_bank),
    .cfg_open_wait(cfg_open_wait), .cfg_page_wait(cfg_page_wait),
    .cfg_burst_wait(cfg_burst_wait), .cfg_precharge(cfg_precharge),
    .cap(cap), .ma_op(ma_op), .open_set(open_set), .open_clr(open_clr),
    .ras_on_d(ras_on_d), .ras_bank_d(ras_bank_d),
    .cas_n(cas_n), .dtack_n(dtack_n), .ref_gnt(ref_gnt)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_ras
    logic ras_q;
    always_ff @(posedge clk) begin
      if (rst) ras_q <= 1'b1;
      else     ras_q <= !(ras_on_d && (ras_bank_d == BANK_W'(b)));
    end
    assign ras_n[b] = ras_q;
  end

  AST_SINGLE_RAS: assert property (@(posedge clk) disable iff (rst)
    $countones(~ras_n) <= 1); // R2
  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> !(&ras_n)); // R5
  AST_GNT_ALL_RAS_HIGH: assert property (@(posedge clk) disable iff (rst)
    ref_gnt |-> (&ras_n)); // R10

endmodule

// File: tb/sim_dram_page_seq.sv
module sim_dram_page_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ads_n = 1'b1;
  logic [19:0] addr = '0;
  logic        burst_req = 1'b0;
  logic        ref_req = 1'b0;
  logic [2:0]  cfg_open_wait = 3'd2;
  logic [2:0]  cfg_page_wait = 3'd1;
  logic [2:0]  cfg_burst_wait = 3'd1;
  logic [2:0]  cfg_precharge = 3'd3;
  logic [1:0]  cfg_wrap_sel = 2'd1;
  logic [1:0]  ras_n;
  logic        cas_n;
  logic [9:0]  ma;
  logic        dtack_n;
  logic        ref_gnt;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  dram_page_seq u0 (
    .clk(clk), .rst(rst), .ads_n(ads_n), .addr(addr), .burst_req(burst_req),
    .ref_req(ref_req), .cfg_open_wait(cfg_open_wait), .cfg_page_wait(cfg_page_wait),
    .cfg_burst_wait(cfg_burst_wait), .cfg_precharge(cfg_precharge),
    .cfg_wrap_sel(cfg_wrap_sel), .ras_n(ras_n), .cas_n(cas_n), .ma(ma),
    .dtack_n(dtack_n), .ref_gnt(ref_gnt)
  );

  function automatic logic [19:0] mk(input int bank, input int row, input int col);
    return {bank[0], row[9:0], col[8:0]};
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [19:0] a);
    addr  = a;
    ads_n = 1'b0;
    step();
    ads_n = 1'b1;
  endtask

  task automatic t_reset();
    step(); step();
    chk("R1 ras_n", ras_n, 3);
    chk("R1 cas_n", cas_n, 1);
    chk("R1 dtack_n", dtack_n, 1);
    chk("R1 ref_gnt", ref_gnt, 0);
    rst = 1'b0;
    step();
  endtask

  task automatic t_opening();
    strobe(mk(0, 5, 8));
    chk("R2 ras bank0", ras_n, 2);
    chk("R2 row on ma", ma, 5);
    chk("R2 cas high", cas_n, 1);
    step();
    chk("R2 col on ma", ma, 8);
    chk("R2 cas low", cas_n, 0);
    step();
    chk("R3 no ack yet", dtack_n, 1);
    step();
    chk("R3 ack at E+3", dtack_n, 0);
    step();
    chk("R4 ack one clock", dtack_n, 1);
    chk("R4 cas with ack", cas_n, 1);
    chk("R5 row held", ras_n, 2);
  endtask

  task automatic t_page_hit();
    strobe(mk(0, 5, 20));
    chk("R6 ras kept", ras_n, 2);
    chk("R6 col at E", ma, 20);
    chk("R6 cas at E", cas_n, 0);
    chk("R6 no ack at E", dtack_n, 1);
    step();
    chk("R6 ack at E+1", dtack_n, 0);
    step();
    chk("R4 ack ends", dtack_n, 1);
  endtask

  task automatic t_burst4();
    burst_req = 1'b1;
    strobe(mk(0, 5, 13));
    chk("R8 first col", ma, 13);
    step();
    chk("R8 first ack", dtack_n, 0);
    step();
    chk("R8 next col", ma, 14);
    chk("R8 cas gap", cas_n, 1);
    step();
    chk("R8 cas again", cas_n, 0);
    chk("R8 no ack in wait", dtack_n, 1);
    step();
    chk("R8 beat ack", dtack_n, 0);
    step();
    chk("R8 col 15", ma, 15);
    step(); step(); step();
    chk("R9 wrap to base", ma, 12);
    burst_req = 1'b0;
    step(); step();
    chk("R8 last ack", dtack_n, 0);
    step();
    chk("R5 burst ends open", ras_n, 2);
    chk("R5 cas high", cas_n, 1);
    chk("R9 col kept", ma, 12);
  endtask

  task automatic t_wrap2();
    cfg_wrap_sel = 2'd0;
    burst_req    = 1'b1;
    strobe(mk(0, 5, 7));
    step();
    step();
    burst_req = 1'b0;
    chk("R9 size2 wrap", ma, 6);
    step(); step();
    chk("R8 ack", dtack_n, 0);
    step();
    cfg_wrap_sel = 2'd1;
  endtask

  task automatic t_page_miss();
    strobe(mk(1, 9, 3));
    chk("R7 all ras high E", ras_n, 3);
    step();
    chk("R7 all ras high E+1", ras_n, 3);
    step();
    chk("R7 all ras high E+2", ras_n, 3);
    step();
    chk("R7 reopen bank1", ras_n, 1);
    chk("R7 new row", ma, 9);
    step();
    chk("R7 col", ma, 3);
    step();
    chk("R7 no early ack", dtack_n, 1);
    step();
    chk("R7 opening ack", dtack_n, 0);
    step();
  endtask

  task automatic t_ignored();
    strobe(mk(1, 9, 30));
    addr  = mk(0, 2, 2);
    ads_n = 1'b0;
    step();
    ads_n = 1'b1;
    chk("R12 ack on time", dtack_n, 0);
    chk("R12 ma unchanged", ma, 30);
    step();
    chk("R12 row kept", ras_n, 1);
    strobe(mk(1, 9, 31));
    chk("R12 still a hit", cas_n, 0);
    chk("R12 hit col", ma, 31);
    step(); step();
  endtask

  task automatic t_refresh();
    ref_req = 1'b1;
    step();
    chk("R10 precharge first", ras_n, 3);
    chk("R10 no early grant", ref_gnt, 0);
    strobe(mk(1, 9, 4));
    step(); step();
    chk("R10 grant", ref_gnt, 1);
    chk("R10 rows closed", ras_n, 3);
    step();
    chk("R10 grant held", ref_gnt, 1);
    chk("R11 ack held off", dtack_n, 1);
    ref_req = 1'b0;
    step();
    chk("R11 opens after refresh", ras_n, 1);
    chk("R11 row", ma, 9);
    chk("R10 grant dropped", ref_gnt, 0);
    step();
    chk("R11 col", ma, 4);
    step();
    chk("R10 same row uses opening timing", dtack_n, 1);
    step();
    chk("R11 ack", dtack_n, 0);
    step();
  endtask

  initial begin
    t_reset();
    t_opening();
    t_page_hit();
    t_burst4();
    t_wrap2();
    t_page_miss();
    t_ignored();
    t_refresh();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule